// File: doc/BRIEF.md
# Dual-Channel DMA Register Front End

This block is the software-visible register file for up to four DMA channels (two by default). A simple word-wide bus writes and reads per-channel registers that hold the transfer byte count, source and destination addresses, the next descriptor pointer, a control word, a priority value, a completion interrupt mask and a sticky completion status. A read-only register reflects the descriptor the data-movement engine is currently working on. The engine itself sits outside and connects through level outputs (register contents, enable, decoded burst and sample sizes), a single-cycle fetch command pulse, and inputs for completion events, the active flag and the current descriptor.

Each channel raises its own interrupt request when its completion status is set and unmasked. A combined request is raised while any channel has one, so that a single handler can serve all channels from one line. Writes take effect on the clock edge that samples them. Reads are combinational from the address presented.

Top module: `tdma_regfile`

## Requirements
- R1: While reset is asserted, and right after it is released, every register reads zero and every output (interrupts, fetch pulse, enable, register mirrors) is low.
- R2: Register offsets (address bits 7:4) are 0x0 byte count, 0x1 source, 0x2 destination, 0x3 next descriptor, 0x4 control, 0x6 priority, 0x7 current descriptor, 0x8 interrupt mask, 0xA interrupt status; channel n is selected by address bits 3:2 equal to n, giving byte address base+4*n. Written values read back the cycle after the write: byte count keeps its low 24 bits, priority its low 4 bits, mask and status bit 0. The mirror outputs carry the stored values.
- R3: Addresses with bits 1:0 non-zero, a channel index not below the channel count, or an unlisted offset read as zero, and writes to them change nothing. Writes to the current descriptor register are ignored; it reads the engine's current-descriptor input.
- R4: Control holds writable bits 24:22 sample size, 21 peripheral mode, 20 abort, 17 close-descriptor enable, 16 pack mode, 12 enable, 10 interrupt mode, 9 chain mode, 8:6 burst size, 5:4 destination direction, 3:2 source direction (writable mask 0x01F317FC); bit 14 reads the engine's active input, bit 13 reads zero, all other bits read zero. Bit 12 drives the enable output.
- R5: A control write with bit 13 set makes that channel's fetch output high for exactly the one cycle following the write edge.
- R6: Sample size codes 0,1,2,3,4,5 decode to 8,12,16,20,24,32 bits on the sample output; codes 6 and 7 decode to 0.
- R7: Burst size codes 0,1,3,6,7,5 decode to 4,8,16,32,64,128 bytes on the burst output; codes 2 and 4 decode to 0.
- R8: A completion event sets status bit 0, which stays set until software writes the status register with bit 0 zero; writing bit 0 as one has no effect.
- R9: A completion event in the same cycle as a clearing status write wins: the status stays set.
- R10: A channel's interrupt output is high exactly when its status bit and mask bit are both set.
- R11: A control write that clears bit 12 while it was set also clears that channel's mask bit; a control write with bit 12 zero while it was already zero leaves the mask alone.
- R12: The combined interrupt output is high exactly when any channel's interrupt output is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write strobe for the addressed register |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| done_i | input | NUM_CH | Completion event per channel, one cycle |
| active_i | input | NUM_CH | Engine busy flag per channel |
| cur_desc_i | input | NUM_CH*32 | Descriptor in use per channel |
| byte_cnt_o | output | NUM_CH*CNT_W | Byte count per channel |
| src_addr_o | output | NUM_CH*32 | Source address per channel |
| dst_addr_o | output | NUM_CH*32 | Destination address per channel |
| next_desc_o | output | NUM_CH*32 | Next descriptor per channel |
| ctrl_o | output | NUM_CH*32 | Stored control bits per channel |
| prio_o | output | NUM_CH*PRIO_W | Priority per channel |
| enable_o | output | NUM_CH | Channel enable |
| fetch_o | output | NUM_CH | Fetch-next-descriptor command pulse |
| burst_bytes_o | output | NUM_CH*8 | Decoded burst length in bytes |
| sample_bits_o | output | NUM_CH*6 | Decoded sample width in bits |
| irq_o | output | NUM_CH | Per-channel interrupt request |
| irq_any_o | output | 1 | Combined interrupt request |

## Verification
The assertions assume completion events and bus writes come from well-behaved sources: a completion pulse and a bus write are only sampled on clock edges, and no completion is presented while reset is held, since the checks that look one cycle back are gated until the first full cycle after reset. The bench keeps to this by driving every input on the falling edge, holding done_i and we_i low through reset, and raising each write and completion for exactly one cycle. Collisions such as a clearing write meeting a completion, and a disable write meeting a set mask, are produced deliberately within those rules.

// File: rtl/tdma_reg_pkg.sv
package tdma_reg_pkg;

  localparam int DW = 32;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_CNT, SEL_SRC, SEL_DST, SEL_NXT,
    SEL_CTL, SEL_PRI, SEL_CUR, SEL_MSK, SEL_STS
  } reg_sel_e;

  // offset nibble, address bits 7:4
  localparam logic [3:0] OFS_CNT = 4'h0;
  localparam logic [3:0] OFS_SRC = 4'h1;
  localparam logic [3:0] OFS_DST = 4'h2;
  localparam logic [3:0] OFS_NXT = 4'h3;
  localparam logic [3:0] OFS_CTL = 4'h4;
  localparam logic [3:0] OFS_PRI = 4'h6;
  localparam logic [3:0] OFS_CUR = 4'h7;
  localparam logic [3:0] OFS_MSK = 4'h8;
  localparam logic [3:0] OFS_STS = 4'hA;

  localparam int BIT_EN    = 12;
  localparam int BIT_FETCH = 13;
  localparam int BIT_ACT   = 14;
  localparam int BURST_LO  = 6;
  localparam int SAMPLE_LO = 22;

  localparam logic [DW-1:0] CTRL_WMASK = 32'h01F3_17FC;

  function automatic logic [7:0] burst_bytes(input logic [2:0] code);
    case (code)
      3'd0:    return 8'd4;
      3'd1:    return 8'd8;
      3'd3:    return 8'd16;
      3'd6:    return 8'd32;
      3'd7:    return 8'd64;
      3'd5:    return 8'd128;
      default: return 8'd0;
    endcase
  endfunction

  function automatic logic [5:0] sample_bits(input logic [2:0] code);
    case (code)
      3'd0:    return 6'd8;
      3'd1:    return 6'd12;
      3'd2:    return 6'd16;
      3'd3:    return 6'd20;
      3'd4:    return 6'd24;
      3'd5:    return 6'd32;
      default: return 6'd0;
    endcase
  endfunction

endpackage

// File: rtl/tdma_addr_dec.sv
module tdma_addr_dec
  import tdma_reg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NUM_CH = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NUM_CH-1:0] ch_hit_o,
  output reg_sel_e          sel_o
);

  logic       hi_zero;
  logic [1:0] ch_idx;
  logic       slot_ok;

  assign hi_zero = ((addr_i >> 8) == '0);
  assign ch_idx  = addr_i[3:2];
  assign slot_ok = hi_zero && (addr_i[1:0] == 2'b00) && (int'(ch_idx) < NUM_CH);

  always_comb begin
    sel_o = SEL_NONE;
    if (slot_ok) begin
      case (addr_i[7:4])
        OFS_CNT: sel_o = SEL_CNT;
        OFS_SRC: sel_o = SEL_SRC;
        OFS_DST: sel_o = SEL_DST;
        OFS_NXT: sel_o = SEL_NXT;
        OFS_CTL: sel_o = SEL_CTL;
        OFS_PRI: sel_o = SEL_PRI;
        OFS_CUR: sel_o = SEL_CUR;
        OFS_MSK: sel_o = SEL_MSK;
        OFS_STS: sel_o = SEL_STS;
        default: sel_o = SEL_NONE;
      endcase
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_hit
    assign ch_hit_o[c] = (sel_o != SEL_NONE) && (ch_idx == 2'(c));
  end

endmodule

// File: rtl/tdma_chan_regs.sv
module tdma_chan_regs
  import tdma_reg_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int PRIO_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  reg_sel_e          sel_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              done_i,
  input  logic              active_i,
  input  logic [DW-1:0]     cur_desc_i,
  output logic [DW-1:0]     rdata_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [DW-1:0]     src_o,
  output logic [DW-1:0]     dst_o,
  output logic [DW-1:0]     nxt_o,
  output logic [DW-1:0]     ctrl_o,
  output logic [PRIO_W-1:0] prio_o,
  output logic              enable_o,
  output logic              fetch_o,
  output logic              msk_o,
  output logic              sts_o,
  output logic [7:0]        burst_bytes_o,
  output logic [5:0]        sample_bits_o
);

  logic [CNT_W-1:0]  cnt_q;
  logic [DW-1:0]     src_q, dst_q, nxt_q, ctrl_q;
  logic [PRIO_W-1:0] prio_q;
  logic              msk_q, sts_q, fetch_q;
  logic              sts_clr;

  assign sts_clr = wr_i && (sel_i == SEL_STS) && !wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      src_q   <= '0;
      dst_q   <= '0;
      nxt_q   <= '0;
      ctrl_q  <= '0;
      prio_q  <= '0;
      msk_q   <= 1'b0;
      fetch_q <= 1'b0;
    end else begin
      fetch_q <= 1'b0;
      if (wr_i) begin
        case (sel_i)
          SEL_CNT: cnt_q  <= wdata_i[CNT_W-1:0];
          SEL_SRC: src_q  <= wdata_i;
          SEL_DST: dst_q  <= wdata_i;
          SEL_NXT: nxt_q  <= wdata_i;
          SEL_PRI: prio_q <= wdata_i[PRIO_W-1:0];
          SEL_MSK: msk_q  <= wdata_i[0];
          SEL_CTL: begin
            ctrl_q  <= wdata_i & CTRL_WMASK;
            fetch_q <= wdata_i[BIT_FETCH];
            // disabling a running channel also masks its interrupt
            if (ctrl_q[BIT_EN] && !wdata_i[BIT_EN]) msk_q <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  // completion event outranks a clearing write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sts_q <= 1'b0;
    else if (done_i)  sts_q <= 1'b1;
    else if (sts_clr) sts_q <= 1'b0;
  end

  always_comb begin
    rdata_o = '0;
    case (sel_i)
      SEL_CNT: rdata_o[CNT_W-1:0]  = cnt_q;
      SEL_SRC: rdata_o             = src_q;
      SEL_DST: rdata_o             = dst_q;
      SEL_NXT: rdata_o             = nxt_q;
      SEL_PRI: rdata_o[PRIO_W-1:0] = prio_q;
      SEL_CUR: rdata_o             = cur_desc_i;
      SEL_MSK: rdata_o[0]          = msk_q;
      SEL_STS: rdata_o[0]          = sts_q;
      SEL_CTL: begin
        rdata_o          = ctrl_q;
        rdata_o[BIT_ACT] = active_i;
      end
      default: rdata_o = '0;
    endcase
  end

  assign cnt_o         = cnt_q;
  assign src_o         = src_q;
  assign dst_o         = dst_q;
  assign nxt_o         = nxt_q;
  assign ctrl_o        = ctrl_q;
  assign prio_o        = prio_q;
  assign enable_o      = ctrl_q[BIT_EN];
  assign fetch_o       = fetch_q;
  assign msk_o         = msk_q;
  assign sts_o         = sts_q;
  assign burst_bytes_o = burst_bytes(ctrl_q[BURST_LO +: 3]);
  assign sample_bits_o = sample_bits(ctrl_q[SAMPLE_LO +: 3]);

endmodule

// File: rtl/tdma_irq_comb.sv
module tdma_irq_comb #(
  parameter int NUM_CH = 2
) (
  input  logic [NUM_CH-1:0] sts_i,
  input  logic [NUM_CH-1:0] msk_i,
  output logic [NUM_CH-1:0] irq_o,
  output logic              irq_any_o
);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_irq
    assign irq_o[c] = sts_i[c] & msk_i[c];
  end

  assign irq_any_o = |irq_o;

endmodule

// File: rtl/tdma_regfile.sv
module tdma_regfile
  import tdma_reg_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 24,
  parameter int PRIO_W = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [31:0]              wdata_i,
  output logic [31:0]              rdata_o,
  input  logic [NUM_CH-1:0]        done_i,
  input  logic [NUM_CH-1:0]        active_i,
  input  logic [NUM_CH*32-1:0]     cur_desc_i,
  output logic [NUM_CH*CNT_W-1:0]  byte_cnt_o,
  output logic [NUM_CH*32-1:0]     src_addr_o,
  output logic [NUM_CH*32-1:0]     dst_addr_o,
  output logic [NUM_CH*32-1:0]     next_desc_o,
  output logic [NUM_CH*32-1:0]     ctrl_o,
  output logic [NUM_CH*PRIO_W-1:0] prio_o,
  output logic [NUM_CH-1:0]        enable_o,
  output logic [NUM_CH-1:0]        fetch_o,
  output logic [NUM_CH*8-1:0]      burst_bytes_o,
  output logic [NUM_CH*6-1:0]      sample_bits_o,
  output logic [NUM_CH-1:0]        irq_o,
  output logic                     irq_any_o
);

  reg_sel_e          sel;
  logic [NUM_CH-1:0] ch_hit;
  logic [NUM_CH-1:0] sts_vec, msk_vec;
  logic [DW-1:0]     rd_ch [NUM_CH];

  tdma_addr_dec #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) u_dec (
    .addr_i   (addr_i),
    .ch_hit_o (ch_hit),
    .sel_o    (sel)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    tdma_chan_regs #(.CNT_W(CNT_W), .PRIO_W(PRIO_W)) u_regs (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .wr_i          (we_i && ch_hit[c]),
      .sel_i         (sel),
      .wdata_i       (wdata_i),
      .done_i        (done_i[c]),
      .active_i      (active_i[c]),
      .cur_desc_i    (cur_desc_i[c*32 +: 32]),
      .rdata_o       (rd_ch[c]),
      .cnt_o         (byte_cnt_o[c*CNT_W +: CNT_W]),
      .src_o         (src_addr_o[c*32 +: 32]),
      .dst_o         (dst_addr_o[c*32 +: 32]),
      .nxt_o         (next_desc_o[c*32 +: 32]),
      .ctrl_o        (ctrl_o[c*32 +: 32]),
      .prio_o        (prio_o[c*PRIO_W +: PRIO_W]),
      .enable_o      (enable_o[c]),
      .fetch_o       (fetch_o[c]),
      .msk_o         (msk_vec[c]),
      .sts_o         (sts_vec[c]),
      .burst_bytes_o (burst_bytes_o[c*8 +: 8]),
      .sample_bits_o (sample_bits_o[c*6 +: 6])
    );
  end

  always_comb begin
    rdata_o = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (ch_hit[c]) rdata_o = rdata_o | rd_ch[c];
    end
  end

  tdma_irq_comb #(.NUM_CH(NUM_CH)) u_irq (
    .sts_i     (sts_vec),
    .msk_i     (msk_vec),
    .irq_o     (irq_o),
    .irq_any_o (irq_any_o)
  );

endmodule

// File: rtl/tdma_regfile_chk.sv
module tdma_regfile_chk #(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wd0_i,
  input logic              wd13_i,
  input logic [31:0]       rdata_o,
  input logic [NUM_CH-1:0] done_i,
  input logic [NUM_CH-1:0] enable_o,
  input logic [NUM_CH-1:0] fetch_o,
  input logic [NUM_CH-1:0] irq_o,
  input logic              irq_any_o,
  input logic [NUM_CH-1:0] sts_i,
  input logic [NUM_CH-1:0] msk_i
);

  // high once one full cycle has passed since reset release
  logic live_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) live_q <= 1'b0;
    else         live_q <= 1'b1;
  end

  assert_misaligned_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[1:0] != 2'b00) |-> (rdata_o == 32'h0));

  assert_any_tracks_each_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_any_o == (irq_o != '0));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam logic [ADDR_W-1:0] CTL_A = ADDR_W'(32'h40 + 32'(4 * c));
    localparam logic [ADDR_W-1:0] STS_A = ADDR_W'(32'hA0 + 32'(4 * c));

    assert_fetch_from_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (live_q && fetch_o[c]) |-> $past(we_i && (addr_i == CTL_A) && wd13_i));

    assert_clear_takes_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (live_q && $past(we_i && (addr_i == STS_A) && !wd0_i && !done_i[c])) |-> !sts_i[c]);

    assert_done_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (live_q && $past(done_i[c])) |-> sts_i[c]);

    assert_irq_follows_done_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (live_q && $past(done_i[c]) && msk_i[c]) |-> irq_o[c]);

    assert_disable_masks_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (live_q && $fell(enable_o[c])) |-> !msk_i[c]);
  end

endmodule

bind tdma_regfile tdma_regfile_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .wd0_i     (wdata_i[0]),
  .wd13_i    (wdata_i[13]),
  .rdata_o   (rdata_o),
  .done_i    (done_i),
  .enable_o  (enable_o),
  .fetch_o   (fetch_o),
  .irq_o     (irq_o),
  .irq_any_o (irq_any_o),
  .sts_i     (sts_vec),
  .msk_i     (msk_vec)
);

// File: tb/sim_tdma_regfile.sv
module sim_tdma_regfile;

  localparam int CLK_PERIOD = 10;
  localparam int NCH = 2;
  localparam logic [31:0] WMASK = 32'h01F3_17FC;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  done = '0;
  logic [1:0]  active = '0;
  logic [31:0] cur_desc [NCH];
  logic [63:0] cur_flat;
  logic [47:0] cnt_o;
  logic [63:0] src_o, dst_o, nxt_o, ctl_o;
  logic [7:0]  prio_o;
  logic [1:0]  en_o, fetch_o, irq_o;
  logic [15:0] burst_o;
  logic [11:0] sample_o;
  logic        irq_any;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign cur_flat = {cur_desc[1], cur_desc[0]};

  tdma_regfile u0 (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .done_i(done), .active_i(active), .cur_desc_i(cur_flat),
    .byte_cnt_o(cnt_o), .src_addr_o(src_o), .dst_addr_o(dst_o),
    .next_desc_o(nxt_o), .ctrl_o(ctl_o), .prio_o(prio_o), .enable_o(en_o),
    .fetch_o(fetch_o), .burst_bytes_o(burst_o), .sample_bits_o(sample_o),
    .irq_o(irq_o), .irq_any_o(irq_any)
  );

  // reference model state
  logic [31:0] m_cnt [NCH], m_src [NCH], m_dst [NCH], m_nxt [NCH], m_ctl [NCH], m_pri [NCH];
  logic        m_msk [NCH], m_sts [NCH], m_fetch [NCH];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        m_cnt[c] <= 0; m_src[c] <= 0; m_dst[c] <= 0; m_nxt[c] <= 0;
        m_ctl[c] <= 0; m_pri[c] <= 0; m_msk[c] <= 0; m_sts[c] <= 0; m_fetch[c] <= 0;
      end
    end else begin
      int ch;
      ch = int'(addr[3:2]);
      for (int c = 0; c < NCH; c++) m_fetch[c] <= 1'b0;
      if (we && addr[1:0] == 2'b00 && ch < NCH) begin
        case (addr[7:4])
          4'h0: m_cnt[ch] <= wdata & 32'h00FF_FFFF;
          4'h1: m_src[ch] <= wdata;
          4'h2: m_dst[ch] <= wdata;
          4'h3: m_nxt[ch] <= wdata;
          4'h6: m_pri[ch] <= wdata & 32'hF;
          4'h8: m_msk[ch] <= wdata[0];
          4'hA: if (!wdata[0]) m_sts[ch] <= 1'b0;
          4'h4: begin
            m_ctl[ch]   <= wdata & WMASK;
            m_fetch[ch] <= wdata[13];
            if (m_ctl[ch][12] && !wdata[12]) m_msk[ch] <= 1'b0;
          end
          default: ;
        endcase
      end
      for (int c = 0; c < NCH; c++) if (done[c]) m_sts[c] <= 1'b1;
    end
  end

  function automatic logic [31:0] mdl_read(input logic [7:0] a);
    int ch;
    ch = int'(a[3:2]);
    if (a[1:0] != 2'b00 || ch >= NCH) return 32'h0;
    case (a[7:4])
      4'h0: return m_cnt[ch];
      4'h1: return m_src[ch];
      4'h2: return m_dst[ch];
      4'h3: return m_nxt[ch];
      4'h4: return m_ctl[ch] | (32'(active[ch]) << 14);
      4'h6: return m_pri[ch];
      4'h7: return cur_desc[ch];
      4'h8: return 32'(m_msk[ch]);
      4'hA: return 32'(m_sts[ch]);
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [7:0] exp_burst(input int code);
    case (code)
      0: return 8'd4;   1: return 8'd8;   3: return 8'd16;
      6: return 8'd32;  7: return 8'd64;  5: return 8'd128;
      default: return 8'd0;
    endcase
  endfunction

  function automatic logic [5:0] exp_sample(input int code);
    case (code)
      0: return 6'd8;  1: return 6'd12; 2: return 6'd16;
      3: return 6'd20; 4: return 6'd24; 5: return 6'd32;
      default: return 6'd0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // compare against the model on every clock
  always @(negedge clk) begin
    if (rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        check($sformatf("R10 irq ch%0d", c), 32'(irq_o[c]), 32'(m_sts[c] & m_msk[c]));
        check($sformatf("R5 fetch ch%0d", c), 32'(fetch_o[c]), 32'(m_fetch[c]));
        check($sformatf("R4 enable ch%0d", c), 32'(en_o[c]), 32'(m_ctl[c][12]));
        check($sformatf("R2 ctrl mirror ch%0d", c), ctl_o[c*32 +: 32], m_ctl[c]);
        check($sformatf("R2 cnt mirror ch%0d", c), 32'(cnt_o[c*24 +: 24]), m_cnt[c]);
        check($sformatf("R2 src mirror ch%0d", c), src_o[c*32 +: 32], m_src[c]);
        check($sformatf("R2 dst mirror ch%0d", c), dst_o[c*32 +: 32], m_dst[c]);
        check($sformatf("R2 nxt mirror ch%0d", c), nxt_o[c*32 +: 32], m_nxt[c]);
        check($sformatf("R2 prio mirror ch%0d", c), 32'(prio_o[c*4 +: 4]), m_pri[c]);
      end
      check("R12 combined irq", 32'(irq_any), 32'((m_sts[0] & m_msk[0]) | (m_sts[1] & m_msk[1])));
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    addr = a;
    #1;
    check(tag, rdata, mdl_read(a));
  endtask

  task automatic rd_exp(input logic [7:0] a, input logic [31:0] exp, input string tag);
    addr = a;
    #1;
    check(tag, rdata, exp);
  endtask

  task automatic pulse_done(input int c);
    @(negedge clk);
    done[c] = 1'b1;
    @(negedge clk);
    done[c] = 1'b0;
  endtask

  task automatic rd_all(input string tag);
    logic [3:0] offs [9] = '{4'h0, 4'h1, 4'h2, 4'h3, 4'h4, 4'h6, 4'h7, 4'h8, 4'hA};
    for (int c = 0; c < NCH; c++)
      for (int k = 0; k < 9; k++) rd({offs[k], 2'(c), 2'b00}, tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] bad [7] = '{8'h50, 8'h90, 8'hB0, 8'hF0, 8'h08, 8'h0C, 8'h42};
    cur_desc[0] = 32'h0000_0000;
    cur_desc[1] = 32'h0000_0000;
    repeat (3) @(posedge clk);
    // R1: reset state
    rd_all("R1 reset read");
    check("R1 reset irq", 32'({irq_any, irq_o}), 32'h0);
    check("R1 reset fetch/enable", 32'({fetch_o, en_o}), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd_all("R1 after release");

    // R2: write/read back every writable register
    for (int c = 0; c < NCH; c++) begin
      logic [7:0] cb;
      cb = 8'(4 * c);
      wr(8'h00 + cb, 32'hDEAD_BEEF ^ c);
      wr(8'h10 + cb, 32'h1234_5678 + c);
      wr(8'h20 + cb, 32'h8765_4321 - c);
      wr(8'h30 + cb, 32'h0000_0100 * (c + 1));
      wr(8'h60 + cb, 32'hFFFF_FFF0 | c);
      wr(8'h80 + cb, 32'h0000_0001);
    end
    rd_all("R2 readback");
    rd_exp(8'h10, 32'h1234_5678, "R2 src ch0");
    rd_exp(8'h24, 32'h8765_4320, "R2 dst ch1");
    rd_exp(8'h04, 32'h00AD_BEEE, "R2 cnt ch1 24 bits");
    rd_exp(8'h64, 32'h0000_0001, "R2 prio ch1 4 bits");

    // R3: current descriptor read-only, unmapped addresses inert
    cur_desc[0] = 32'hC0DE_0010;
    cur_desc[1] = 32'hC0DE_0020;
    wr(8'h70, 32'hFFFF_FFFF);
    rd_exp(8'h70, 32'hC0DE_0010, "R3 cur desc ch0 read-only");
    rd_exp(8'h74, 32'hC0DE_0020, "R2 cur desc ch1");
    for (int k = 0; k < 7; k++) wr(bad[k], 32'hFFFF_FFFF);
    for (int k = 0; k < 7; k++) rd_exp(bad[k], 32'h0, "R3 unmapped read");
    rd_all("R3 mapped untouched");
    rd_exp(8'h40, 32'h0, "R3 misaligned write missed ctrl");

    // R4: control layout and read-only bits
    active = 2'b01;
    wr(8'h40, 32'hFFFF_DFFF);
    rd_exp(8'h40, WMASK | 32'h0000_4000, "R4 ctrl mask with active");
    active = 2'b00;
    rd_exp(8'h40, WMASK, "R4 ctrl mask idle");
    wr(8'h40, 32'h0);

    // R5: fetch pulse
    wr(8'h44, 32'h0000_2000);
    check("R5 fetch high", 32'(fetch_o), 32'h2);
    rd_exp(8'h44, 32'h0, "R5 fetch reads zero");
    @(negedge clk);
    check("R5 fetch one cycle", 32'(fetch_o), 32'h0);

    // R6, R7: decoded sizes
    for (int code = 0; code < 8; code++) begin
      wr(8'h40, 32'(code) << 22);
      check($sformatf("R6 sample code %0d", code), 32'(sample_o[5:0]), 32'(exp_sample(code)));
      wr(8'h44, 32'(code) << 6);
      check($sformatf("R7 burst code %0d", code), 32'(burst_o[15:8]), 32'(exp_burst(code)));
    end

    // R8: sticky status
    wr(8'h80, 32'h0);
    pulse_done(0);
    repeat (3) @(negedge clk);
    rd_exp(8'hA0, 32'h1, "R8 status sticky");
    check("R10 masked no irq", 32'(irq_o[0]), 32'h0);
    wr(8'hA0, 32'h1);
    rd_exp(8'hA0, 32'h1, "R8 write one no effect");
    wr(8'hA0, 32'h0);
    rd_exp(8'hA0, 32'h0, "R8 write zero clears");

    // R9: event beats clear
    pulse_done(1);
    @(negedge clk);
    we = 1'b1; addr = 8'hA4; wdata = 32'h0; done[1] = 1'b1;
    @(negedge clk);
    we = 1'b0; done[1] = 1'b0;
    rd_exp(8'hA4, 32'h1, "R9 done wins over clear");

    // R10, R12: unmask
    wr(8'h84, 32'h1);
    check("R10 irq ch1", 32'(irq_o), 32'h2);
    check("R12 any from ch1", 32'(irq_any), 32'h1);
    wr(8'hA4, 32'h0);
    check("R12 any low", 32'(irq_any), 32'h0);

    // R11: disable masks, idle write does not
    wr(8'h80, 32'h1);
    wr(8'h40, 32'h0000_1000);
    rd_exp(8'h80, 32'h1, "R11 mask kept while enabled");
    wr(8'h40, 32'h0);
    rd_exp(8'h80, 32'h0, "R11 disable clears mask");
    wr(8'h80, 32'h1);
    wr(8'h40, 32'h0000_0200);
    rd_exp(8'h80, 32'h1, "R11 idle write keeps mask");
    pulse_done(0);
    check("R10 irq ch0", 32'(irq_o), 32'h1);
    rd_all("R2 final sweep");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule